// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a small three-wire serial EEPROM. The host places a word address on `word_addr`, picks the part size on `wide_part` and pulses `start`. The block opens the device with chip select and clocks out the read opcode followed by the address. It then clocks in sixteen data bits and closes the device again. When the word is ready, `done` pulses for one cycle and the word appears on `rd_data`. It stays there until the next read completes.

Two sizes of device are supported, and the choice is made for each read. The small size uses a 6-bit word address, so the frame is 9 bits. The large size uses an 8-bit word address, so the frame is 11 bits. Every level placed on the device pins is held for `HALF_DIV` system clocks before the next change. This gives slow devices time to settle. The data line from the device passes through a two-flop synchronizer before it is used.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is asserted and right after it, `ee_cs`, `ee_sk`, `ee_di` and `done` are 0 and `rd_data` is 0.
- R2: A `start` seen while idle begins a read. From the next cycle, `ee_cs` is 1 and `ee_sk` is 0 for one half-period before the first frame bit. `ee_sk` is never 1 while `ee_cs` is 0.
- R3: The frame is the opcode 3'b110 followed by the word address, sent most significant bit first. Each bit is placed on `ee_di` while `ee_sk` is 0 and held for one half-period with `ee_sk` 0, then one half-period with `ee_sk` 1. `ee_di` never changes while `ee_sk` is 1.
- R4: With `wide_part`=0, only `word_addr[5:0]` is sent (9-bit frame), and `word_addr[7:6]` has no effect on the pins or on the result.
- R5: With `wide_part`=1, all of `word_addr[7:0]` is sent (11-bit frame).
- R6: Every pin level, including the low-clock step after the frame and the final closed step, lasts exactly `HALF_DIV` system clocks.
- R7: After the frame and one low half-period, sixteen high/low `ee_sk` periods follow. The first bit read is bit 15 of `rd_data`. Each bit is taken from the synchronized `ee_do` at the last system clock of a high half-period.
- R8: After the sixteenth low half-period, `ee_cs` drops while `ee_sk` is 0 and stays 0 for one half-period. Then `done` is 1 for exactly one cycle, with the new word on `rd_data`. `rd_data` changes at no other time.
- R9: `start`, `word_addr` and `wide_part` have no effect while a read is in progress.
- R10: A `start` in the same cycle that `done` is 1 is accepted, so reads can run back to back.
- R11: `ee_do` passes through a two-flop synchronizer. `HALF_DIV` must be at least 2, so that the synchronized value is stable when it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a read (taken only when idle) |
| wide_part | input | 1 | 0: 6-bit address part, 1: 8-bit address part |
| word_addr | input | 8 | Word address to read |
| rd_data | output | 16 | Last word read |
| done | output | 1 | One-cycle pulse when `rd_data` is updated |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
The completion of one read and the acceptance of the next can fall in the same cycle. The `done` pulse and a fresh `start` then meet while the sequencer returns to idle. The bench provokes this by raising `start` for a second read in the very cycle it sees `done` for the first. It then requires the second frame to open on the next cycle, with the same per-clock pin sequence as a read from idle. Separately, a `start` with a different address and part size is pulsed in the middle of a read. Every pin and the result must still match the original read clock for clock.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  localparam int OP_W      = 3;
  localparam logic [OP_W-1:0] OP_READ = 3'b110;
  localparam int NARROW_AW = 6;
  localparam int WIDE_AW   = 8;
  localparam int FRAME_MAX = OP_W + WIDE_AW;
  localparam int DATA_W    = 16;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } pins_t;

  // Frame length in bits for the selected part size.
  function automatic int frame_len(logic wide);
    return wide ? FRAME_MAX : OP_W + NARROW_AW;
  endfunction

  // Opcode and address, right-aligned.
  function automatic logic [FRAME_MAX-1:0] frame_bits(logic wide, logic [WIDE_AW-1:0] addr);
    logic [FRAME_MAX-1:0] f;
    if (wide) f = {OP_READ, addr};
    else      f = {{(WIDE_AW-NARROW_AW){1'b0}}, OP_READ, addr[NARROW_AW-1:0]};
    return f;
  endfunction

  // Index of the final (chip-select low) step.
  function automatic int last_step(int len);
    return 2*len + 2 + 2*DATA_W;
  endfunction

  // True for the high-clock steps of the data phase.
  function automatic logic is_sample(int s, int len);
    int k;
    k = s - (2*len + 2);
    return (k >= 0) && (k < 2*DATA_W) && ((k % 2) == 0);
  endfunction

  // Pin levels for step s of a read.
  function automatic pins_t step_pins(int s, int len, logic [FRAME_MAX-1:0] frame);
    pins_t p;
    logic [FRAME_MAX-1:0] sh;
    int b;
    p = '0;
    if (s == 0) begin
      p.cs = 1'b1;
    end else if (s <= 2*len) begin
      p.cs = 1'b1;
      p.sk = ((s - 1) % 2) == 1;
      b    = len - 1 - (s - 1) / 2;
      sh   = frame >> b;
      p.di = sh[0];
    end else if (s < last_step(len)) begin
      p.cs = 1'b1;
      p.sk = is_sample(s, len);
    end
    return p;
  endfunction
endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || cnt_q == CNT_TOP) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick = run && (cnt_q == CNT_TOP);
endmodule

// File: rtl/mw_sync_chain.sv
module mw_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_eeprom_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide_part,
  input  logic [WIDE_AW-1:0]  word_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                done,
  output logic                ee_cs,
  output logic                ee_sk,
  output logic                ee_di,
  input  logic                ee_do
);
  localparam int MAX_LAST = 2*FRAME_MAX + 2 + 2*DATA_W;
  localparam int STEP_W   = $clog2(MAX_LAST + 1);

  logic                 busy_q, wide_q, done_q;
  logic [STEP_W-1:0]    step_q;
  logic [FRAME_MAX-1:0] frame_q;
  logic [DATA_W-1:0]    shift_q, rd_data_q;
  pins_t                pins_q;

  // Named internal events
  logic step_tick, launch, last_hit, sample_en, do_sync;
  int   cur_len;

  logic              nxt_busy;
  logic [STEP_W-1:0] nxt_step;
  pins_t             nxt_pins;

  mw_half_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .tick(step_tick)
  );

  mw_sync_chain #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ee_do), .q(do_sync)
  );

  always_comb cur_len = frame_len(wide_q);

  assign launch    = start && !busy_q;
  assign last_hit  = step_tick && (int'(step_q) == last_step(cur_len));
  assign sample_en = step_tick && is_sample(int'(step_q), cur_len);

  always_comb begin
    nxt_busy = busy_q;
    nxt_step = step_q;
    nxt_pins = pins_q;
    if (launch) begin
      nxt_busy = 1'b1;
      nxt_step = '0;
      nxt_pins = step_pins(0, cur_len, frame_q);
    end else if (last_hit) begin
      nxt_busy = 1'b0;
      nxt_step = '0;
      nxt_pins = '0;
    end else if (step_tick) begin
      nxt_step = step_q + STEP_W'(1);
      nxt_pins = step_pins(int'(step_q) + 1, cur_len, frame_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      step_q    <= '0;
      pins_q    <= '0;
      wide_q    <= 1'b0;
      frame_q   <= '0;
      shift_q   <= '0;
      rd_data_q <= '0;
      done_q    <= 1'b0;
    end else begin
      busy_q <= nxt_busy;
      step_q <= nxt_step;
      pins_q <= nxt_pins;
      done_q <= last_hit;
      if (launch) begin
        wide_q  <= wide_part;
        frame_q <= frame_bits(wide_part, word_addr);
      end
      if (sample_en) shift_q <= {shift_q[DATA_W-2:0], do_sync};
      if (last_hit)  rd_data_q <= shift_q;
    end
  end

  assign ee_cs   = pins_q.cs;
  assign ee_sk   = pins_q.sk;
  assign ee_di   = pins_q.di;
  assign done    = done_q;
  assign rd_data = rd_data_q;
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di,
  input logic        done,
  input logic [15:0] rd_data,
  input logic        sample_en
);
  // R2
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  // R3
  di_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs && ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  // R7
  sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> ee_sk);

  // R8
  cs_drop_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (!ee_sk && !$past(ee_sk)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .done(done), .rd_data(rd_data), .sample_en(sample_en)
);

// File: tb/mw_eeprom_reader_bench.sv
module mw_eeprom_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide_part = 1'b0;
  logic [7:0]  word_addr = '0;
  logic [15:0] rd_data;
  logic        done, ee_cs, ee_sk, ee_di;
  logic        ee_do_drv = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] last_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_reader #(.HALF_DIV(HALF)) u_mw_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_part(wide_part),
    .word_addr(word_addr), .rd_data(rd_data), .done(done),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do_drv)
  );

  // Behavioural device contents
  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {a ^ 8'h3C, ~a};
  endfunction

  // Behavioural device model
  bit          dev_wide = 0;
  int          m_cnt = 0, m_idx = 0;
  logic        m_prev = 0;
  logic [10:0] m_sh = '0;
  logic [15:0] m_word = '0;
  always @(posedge clk) begin
    int m_len;
    m_len = dev_wide ? 11 : 9;
    if (!ee_cs) begin
      m_cnt = 0; m_idx = 0; m_prev = 0; m_sh = '0;
      ee_do_drv <= 1'b0;
    end else begin
      if (ee_sk && !m_prev && m_cnt < m_len) begin
        m_sh = {m_sh[9:0], ee_di};
        m_cnt++;
        if (m_cnt == m_len) begin
          if ((m_sh >> (m_len - 3)) != 11'd6) m_word = 16'h0000;
          else if (dev_wide) m_word = mem_word(m_sh[7:0]);
          else m_word = mem_word({2'b00, m_sh[5:0]});
          ee_do_drv <= 1'b0;
        end
      end
      if (!ee_sk && m_prev && m_cnt == m_len && m_idx < 16) begin
        ee_do_drv <= m_word[15 - m_idx];
        m_idx++;
      end
      m_prev = ee_sk;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One read; the caller sits at a negedge. Returns at the negedge where done is expected.
  task automatic xfer(input logic [7:0] a, input logic w, input bit poke, input string tag);
    logic [2:0] plan[$];
    int nbits, aw, cmd, cyc;
    logic [15:0] exp;
    aw    = w ? 8 : 6;
    nbits = 3 + aw;
    cmd   = (6 << aw) | (int'(a) & ((1 << aw) - 1));
    exp   = mem_word(w ? a : (a & 8'h3F));
    plan.push_back(3'b100);
    for (int i = nbits - 1; i >= 0; i--) begin
      plan.push_back({2'b10, 1'((cmd >> i) & 1)});
      plan.push_back({2'b11, 1'((cmd >> i) & 1)});
    end
    plan.push_back(3'b100);
    for (int i = 0; i < 16; i++) begin
      plan.push_back(3'b110);
      plan.push_back(3'b100);
    end
    plan.push_back(3'b000);

    dev_wide  = w;
    word_addr = a;
    wide_part = w;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    foreach (plan[k]) begin
      for (int r = 0; r < HALF; r++) begin
        // R2 R3 R6 R7 R9 pin sequence, done low, result held
        check({tag, " R6 pins"}, {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, plan[k]});
        check({tag, " R8 no done"}, {31'd0, done}, 32'd0);
        check({tag, " R8 held"}, {16'd0, rd_data}, {16'd0, last_res});
        if (poke && cyc == 5) begin
          start = 1'b1; word_addr = ~a; wide_part = ~w;
        end else begin
          start = 1'b0;
        end
        cyc++;
        @(negedge clk);
      end
    end
    // R7 R8 R11 result and closing
    check({tag, " R8 done"}, {31'd0, done}, 32'd1);
    check({tag, " R7 R11 data"}, {16'd0, rd_data}, {16'd0, exp});
    check({tag, " R8 closed"}, {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    last_res = exp;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 under reset
    check("R1 pins in reset", {28'd0, ee_cs, ee_sk, ee_di, done}, 32'd0);
    check("R1 data in reset", {16'd0, rd_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pins after reset", {28'd0, ee_cs, ee_sk, ee_di, done}, 32'd0);

    // R4 small part
    xfer(8'h05, 1'b0, 0, "R4 narrow 05");
    @(negedge clk);
    check("R8 idle after done", {28'd0, ee_cs, ee_sk, ee_di, done}, 32'd0);
    // R4 upper address bits ignored
    xfer(8'hC5, 1'b0, 0, "R4 narrow C5");
    @(negedge clk);
    // R5 large part
    xfer(8'hC5, 1'b1, 0, "R5 wide C5");
    @(negedge clk);
    xfer(8'h00, 1'b1, 0, "R5 wide 00");
    @(negedge clk);
    xfer(8'hFF, 1'b1, 0, "R5 wide FF");
    @(negedge clk);
    xfer(8'h3F, 1'b0, 0, "R4 narrow 3F");
    @(negedge clk);
    // R9 start during a read
    xfer(8'h5A, 1'b1, 1, "R9 poke wide");
    @(negedge clk);
    xfer(8'h2A, 1'b0, 1, "R9 poke narrow");
    // R10 back to back: start in the done cycle
    xfer(8'h81, 1'b1, 0, "R10 chain a");
    xfer(8'h17, 1'b0, 0, "R10 chain b");
    @(negedge clk);
    check("R10 idle after chain", {28'd0, ee_cs, ee_sk, ee_di, done}, 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule